// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits between the write-cycle latch of a parallel EEPROM emulation and its page-write engine. It checks every latched write (an address with a data byte) against two fixed command sequences. A three-write unlock-and-lock sequence arms software write protection. A six-write sequence removes it. The block holds the resulting protection flag.

For each write strobe, the block reports exactly one verdict. An accepted write goes to the page-write engine as a data byte. A command write is consumed and never reaches the array. A discarded write is dropped without programming and without polling status. Completing either sequence opens a load window in which every write is accepted. The new protection state is applied when the page-write engine signals the end of its programming period, whether or not any byte was loaded in the window.

The flag is an ordinary register. Its value after reset is set by a parameter.

Top module: `wp_seq_detect`

## Requirements
- R1: After reset, `prot_on` equals the `PROT_RESET` parameter (default 0), no load window is open, and `wr_accept`, `wr_cmd` and `wr_drop` are all 0 while `wr_vld` is 0.
- R2: In every cycle with `wr_vld` high, exactly one of `wr_accept`, `wr_cmd`, `wr_drop` is 1. With `wr_vld` low, all three are 0. The verdict is combinational in the same cycle.
- R3: The writes data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555 are each reported as `wr_cmd`. The third write opens a load window.
- R4: While a load window is open, every write is reported as `wr_accept`, whatever its address or data. The window closes in the cycle after `prog_done` is high.
- R5: After the lock sequence, `prot_on` is 1 from the cycle after the next `prog_done`. This holds even if no data write occurred in the window.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 are each reported as `wr_cmd`. They open a load window, and `prot_on` is 0 from the cycle after the next `prog_done`.
- R7: With `prot_on` = 1 and no window open, a write that is not part of a command sequence is reported as `wr_drop`.
- R8: A write that does not match the next expected step of a partial sequence returns the matcher to idle. That write is treated as data: `wr_accept` when unprotected, `wr_drop` when protected. A later write of the next step of the abandoned sequence is not recognised as a command.
- R9: Only address bits [14:0] are compared with 0x5555 and 0x2AAA. Higher address bits do not affect recognition.
- R10: `prot_on` changes only in the cycle after `prog_done` is high. Completing a sequence alone does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_vld | input | 1 | One latched write cycle present this clock |
| wr_addr | input | ADDR_W (17) | Byte address of the write |
| wr_data | input | DATA_W (8) | Data byte of the write |
| prog_done | input | 1 | Page-write engine finished its programming period |
| prot_on | output | 1 | Software write protection is active |
| wr_accept | output | 1 | Write is passed to the page-write engine as data |
| wr_cmd | output | 1 | Write is consumed as a command byte |
| wr_drop | output | 1 | Write is discarded |

## Verification
Some properties are checked on every cycle by the embedded assertions:
- the one-verdict-per-strobe rule;
- the rule that protection moves only at the end of programming;
- the closing of the window on `prog_done`;
- the step-by-step progress of the six-write disable matcher;
- the absence of discards while unprotected.

Other behaviours need the directed scenarios in the bench:
- the exact byte and address values of each sequence;
- the masking of the upper address bits;
- the non-resumption of a broken sequence;
- protection being applied with an empty window.

// File: rtl/wp_seq_pkg.sv
// Shared types and command constants for the write-protect sequence detector.
// Assumes 8-bit command bytes and a 15-bit compared address field.
package wp_seq_pkg;

    // Position inside a command sequence; U* = shared prefix, X* = disable tail.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_U1   = 3'd1,
        ST_U2   = 3'd2,
        ST_X1   = 3'd3,
        ST_X2   = 3'd4,
        ST_X3   = 3'd5
    } step_e;

    // Pending protection change applied at the end of programming.
    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_SET  = 2'd1,
        PD_CLR  = 2'd2
    } pend_e;

    localparam int unsigned CMP_W = 15;

    localparam logic [7:0] KEY_HI  = 8'hAA;
    localparam logic [7:0] KEY_LO  = 8'h55;
    localparam logic [7:0] OP_LOCK = 8'hA0;
    localparam logic [7:0] OP_PREP = 8'h80;
    localparam logic [7:0] OP_FREE = 8'h20;

    localparam logic [CMP_W-1:0] LOC_A = 15'h5555;
    localparam logic [CMP_W-1:0] LOC_B = 15'h2AAA;

endpackage

// File: rtl/wp_seq_match.sv
// Command sequence matcher.
// Tracks progress through the lock (3 writes) and unlock (6 writes) sequences.
// Flags each write it consumes and pulses lock_done/free_done on the final step.
// Assumes at most one write per clock.
// While hold is high (load window open) it stays idle and consumes nothing.
module wp_seq_match #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic              hold,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              is_cmd,
    output logic              lock_done,
    output logic              free_done
);
    import wp_seq_pkg::*;

    localparam logic [ADDR_W-1:0] CMP_MASK = ADDR_W'((1 << CMP_W) - 1);

    step_e             step_q, step_d;
    logic [ADDR_W-1:0] addr_m;
    logic              at_a, at_b;

    // Compare only the low address field against the command locations.
    always_comb begin
        addr_m = wr_addr & CMP_MASK;
        at_a   = (addr_m == ADDR_W'(LOC_A));
        at_b   = (addr_m == ADDR_W'(LOC_B));
    end

    // Next-step decode; a mismatch at any step returns to idle unconsumed.
    always_comb begin
        step_d    = step_q;
        is_cmd    = 1'b0;
        lock_done = 1'b0;
        free_done = 1'b0;
        if (hold) begin
            step_d = ST_IDLE;
        end else if (wr_vld) begin
            step_d = ST_IDLE;
            unique case (step_q)
                ST_IDLE: if (at_a && wr_data == DATA_W'(KEY_HI)) begin
                    is_cmd = 1'b1; step_d = ST_U1;
                end
                ST_U1: if (at_b && wr_data == DATA_W'(KEY_LO)) begin
                    is_cmd = 1'b1; step_d = ST_U2;
                end
                ST_U2: if (at_a && wr_data == DATA_W'(OP_LOCK)) begin
                    is_cmd = 1'b1; lock_done = 1'b1;
                end else if (at_a && wr_data == DATA_W'(OP_PREP)) begin
                    is_cmd = 1'b1; step_d = ST_X1;
                end
                ST_X1: if (at_a && wr_data == DATA_W'(KEY_HI)) begin
                    is_cmd = 1'b1; step_d = ST_X2;
                end
                ST_X2: if (at_b && wr_data == DATA_W'(KEY_LO)) begin
                    is_cmd = 1'b1; step_d = ST_X3;
                end
                ST_X3: if (at_a && wr_data == DATA_W'(OP_FREE)) begin
                    is_cmd = 1'b1; free_done = 1'b1;
                end
                default: step_d = ST_IDLE;
            endcase
        end
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    // The disable tail is only reached one step at a time.
    AST_TAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_X3) |-> ($past(step_q) == ST_X2 || $past(step_q) == ST_X3)); // R6

    // A completed sequence never coincides with a held (window) cycle.
    AST_NO_DONE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(lock_done || free_done)); // R4

endmodule

// File: rtl/wp_prot_state.sv
// Protection flag, load window and pending change.
// A completed sequence opens the window and records the pending change.
// prog_done applies that change and closes the window.
// Assumes prog_done is a single-cycle pulse from the page-write engine.
module wp_prot_state #(
    parameter logic PROT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_done,
    input  logic free_done,
    input  logic prog_done,
    output logic prot_q,
    output logic window_q
);
    import wp_seq_pkg::*;

    pend_e pend_q;

    // Apply a pending change at end of programming; a new sequence opens a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q   <= PROT_RESET;
            window_q <= 1'b0;
            pend_q   <= PD_NONE;
        end else begin
            if (prog_done) begin
                if (pend_q == PD_SET)      prot_q <= 1'b1;
                else if (pend_q == PD_CLR) prot_q <= 1'b0;
                window_q <= 1'b0;
                pend_q   <= PD_NONE;
            end
            if (lock_done) begin
                window_q <= 1'b1;
                pend_q   <= PD_SET;
            end else if (free_done) begin
                window_q <= 1'b1;
                pend_q   <= PD_CLR;
            end
        end
    end

    AST_PROT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_done |=> $stable(prot_q)); // R10

    AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && !lock_done && !free_done) |=> !window_q); // R4

    AST_LOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_done |=> window_q); // R3

endmodule

// File: rtl/wp_seq_detect.sv
// Top of the write-protect command sequence detector.
// Gives every write strobe one verdict: accept as data, consume as command, or drop.
// Verdicts are combinational in the strobe cycle.
// Assumes one write per clock and a registered protection flag.
module wp_seq_detect #(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned DATA_W     = 8,
    parameter logic        PROT_RESET = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_done,
    output logic              prot_on,
    output logic              wr_accept,
    output logic              wr_cmd,
    output logic              wr_drop
);
    logic is_cmd, lock_done, free_done, window_q, prot_q;

    wp_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_vld    (wr_vld),
        .hold      (window_q),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .is_cmd    (is_cmd),
        .lock_done (lock_done),
        .free_done (free_done)
    );

    wp_prot_state #(.PROT_RESET(PROT_RESET)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_done (lock_done),
        .free_done (free_done),
        .prog_done (prog_done),
        .prot_q    (prot_q),
        .window_q  (window_q)
    );

    // Verdict: window accepts all, then command, then protection decides.
    always_comb begin
        wr_accept = 1'b0;
        wr_cmd    = 1'b0;
        wr_drop   = 1'b0;
        if (wr_vld) begin
            if (window_q)    wr_accept = 1'b1;
            else if (is_cmd) wr_cmd    = 1'b1;
            else if (prot_q) wr_drop   = 1'b1;
            else             wr_accept = 1'b1;
        end
    end

    assign prot_on = prot_q;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vld |-> $onehot({wr_accept, wr_cmd, wr_drop})); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |-> !(wr_accept || wr_cmd || wr_drop)); // R2

    AST_NO_DROP_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_on |-> !wr_drop); // R7

endmodule

// File: tb/wp_seq_detect_test.sv
// Directed bench for wp_seq_detect: one task per scenario, each checking itself.
module wp_seq_detect_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_vld = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_done = 1'b0;
    logic        prot_on, wr_accept, wr_cmd, wr_drop;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wp_seq_detect uut (
        .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_done(prog_done), .prot_on(prot_on),
        .wr_accept(wr_accept), .wr_cmd(wr_cmd), .wr_drop(wr_drop)
    );

    // Verdict codes used by the bench: 1 accept, 2 command, 4 drop.
    localparam logic [2:0] V_ACC = 3'b001, V_CMD = 3'b010, V_DRP = 3'b100, V_NONE = 3'b000;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One write cycle; verdict sampled mid-cycle before the capturing edge.
    task automatic wr(input string tag, input logic [16:0] a, input logic [7:0] d, input logic [2:0] v);
        @(negedge clk);
        wr_vld = 1'b1; wr_addr = a; wr_data = d;
        #1;
        check(tag, {29'd0, wr_drop, wr_cmd, wr_accept}, {29'd0, v});
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    task automatic end_prog();
        @(negedge clk);
        prog_done = 1'b1;
        @(negedge clk);
        prog_done = 1'b0;
    endtask

    task automatic chk_prot(input string tag, input logic exp);
        #1;
        check(tag, {31'd0, prot_on}, {31'd0, exp});
    endtask

    task automatic lock_seq(input string tag);
        wr(tag, 17'h05555, 8'hAA, V_CMD);
        wr(tag, 17'h02AAA, 8'h55, V_CMD);
        wr(tag, 17'h05555, 8'hA0, V_CMD);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 prot", {31'd0, prot_on}, 32'd0);
        check("R1 quiet", {29'd0, wr_drop, wr_cmd, wr_accept}, {29'd0, V_NONE});
    endtask

    task automatic t_plain_unprot();
        wr("R2 plain", 17'h00123, 8'h3C, V_ACC);
        wr("R9 near miss", 17'h05554, 8'hAA, V_ACC);
    endtask

    task automatic t_lock_with_data();
        lock_seq("R3");
        chk_prot("R10 no change before done", 1'b0);
        wr("R4 window", 17'h05555, 8'hAA, V_ACC);
        wr("R4 window", 17'h1F000, 8'h11, V_ACC);
        end_prog();
        chk_prot("R5 set", 1'b1);
        wr("R4 closed", 17'h00010, 8'h22, V_DRP);
    endtask

    task automatic t_drop_prot();
        wr("R7 drop", 17'h00200, 8'h5A, V_DRP);
        wr("R7 drop cmd byte", 17'h02AAA, 8'h55, V_DRP);
    endtask

    task automatic t_break_prot();
        wr("R8 start", 17'h05555, 8'hAA, V_CMD);
        wr("R8 break", 17'h02AAA, 8'h12, V_DRP);
        wr("R8 no resume", 17'h02AAA, 8'h55, V_DRP);
        wr("R8 no resume", 17'h05555, 8'hA0, V_DRP);
        chk_prot("R8 prot kept", 1'b1);
    endtask

    task automatic t_unlock_highbits();
        wr("R9 R6 s1", 17'h15555, 8'hAA, V_CMD);
        wr("R9 R6 s2", 17'h12AAA, 8'h55, V_CMD);
        wr("R6 s3", 17'h05555, 8'h80, V_CMD);
        wr("R6 s4", 17'h05555, 8'hAA, V_CMD);
        wr("R6 s5", 17'h02AAA, 8'h55, V_CMD);
        wr("R6 s6", 17'h05555, 8'h20, V_CMD);
        chk_prot("R10 still set", 1'b1);
        wr("R6 window", 17'h00400, 8'h77, V_ACC);
        end_prog();
        chk_prot("R6 cleared", 1'b0);
        wr("R6 after", 17'h00401, 8'h78, V_ACC);
    endtask

    task automatic t_break_unprot();
        wr("R8 start", 17'h05555, 8'hAA, V_CMD);
        wr("R8 break passes", 17'h00100, 8'h34, V_ACC);
        wr("R8 no resume", 17'h02AAA, 8'h55, V_ACC);
    endtask

    task automatic t_lock_empty();
        lock_seq("R5 empty");
        end_prog();
        chk_prot("R5 empty window", 1'b1);
        wr("R7 after empty", 17'h00050, 8'h01, V_DRP);
        end_prog();
        chk_prot("R10 done without pending", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_unprot();
        t_lock_with_data();
        t_drop_prot();
        t_break_prot();
        t_unlock_highbits();
        t_break_unprot();
        t_lock_empty();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule